// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped, tagged store of branch targets that sits on the instruction fetch path. In every cycle it is looked up with the current fetch address. A hit means the instruction, or the fetch group, at that address holds a branch that was taken the last time it resolved. The block then offers the stored target as the next fetch address. On a miss it offers the sequential address instead: the fetch address plus a fixed step.

When a branch resolves, the back end drives the update port with the branch address, its outcome and its target. A taken outcome writes the entry selected by the branch address and tags it with that address. A not-taken outcome deletes the entry, but only if the entry is currently tagged with that branch. Presence in the buffer therefore works as a one-bit taken prediction. A branch that goes from taken to not-taken and back to taken is mispredicted on both changes.

When several instructions are fetched per cycle, the lookup address is the fetch-group address, and the stored target is that of the first taken branch in the group. The alignment parameter then covers the whole group and the step parameter covers the group size.

Top module: `btb_core`

## Requirements
- R1: A taken update stores its target. From the next clock edge, a lookup whose address matches the update address above the ALIGN_BITS low bits hits, and `next_fetch` equals the stored target with its ALIGN_BITS low bits forced to zero.
- R2: A not-taken update whose address matches a valid entry (same index, same tag) removes it. From the next clock edge a lookup of that address misses.
- R3: A not-taken update whose index holds an entry with a different tag, or no valid entry, leaves the buffer unchanged. Any update changes at most the one entry that its index selects.
- R4: A taken update to an index that already holds an entry with a different tag replaces that entry. The old branch address then misses and the new one hits.
- R5: On a miss, `pred_hit` is 0 and `next_fetch` equals `fetch_addr + STEP_BYTES` (modulo 2^ADDR_W). On a hit, `pred_hit` is 1 and `next_fetch` is the stored target.
- R6: The index is address bits [ALIGN_BITS+IDX_W-1 : ALIGN_BITS], where IDX_W = log2(ENTRIES). The tag is every bit above the index. The ALIGN_BITS low bits of the fetch address and of the update address play no part in the match.
- R7: The lookup is combinational within the cycle. An update that arrives in the same cycle as a lookup of the same address is not forwarded, and only lookups after the next clock edge see it. With no update, the result for an unchanged fetch address does not change.
- R8: A synchronous, active-high reset empties the buffer, so every lookup after reset misses.
- R9: A branch that has been taken, then resolves not-taken, then resolves taken again is mispredicted on both of the last two resolutions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, empties the buffer |
| fetch_addr | input | ADDR_W | Current fetch or fetch-group address |
| pred_hit | output | 1 | Lookup hit: a branch that was taken last time |
| next_fetch | output | ADDR_W | Stored target on a hit, sequential address on a miss |
| upd_valid | input | 1 | A branch resolution is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch or fetch group |
| upd_taken | input | 1 | Outcome: 1 taken, 0 not taken |
| upd_target | input | ADDR_W | Target of the resolved branch |

## Verification
The first pattern fills every index with a distinct tag and target, and each address is then looked up with every low-bit pattern. This shows whether the index and tag are taken from the right bits and whether the alignment bits are ignored. Not-taken updates are then sent both to matching entries and to the same index under a foreign tag, which tells a tag-qualified delete apart from a blind clear. Taken updates under a foreign tag show replacement. A lookup presented in the same cycle as its update shows that nothing is forwarded. A taken, not-taken, taken history counts the mispredictions of the one-bit scheme, and a long pseudo-random mix of lookups and updates over all indices is compared against an arithmetic model of the buffer.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Action the update controller asks of the storage array.
    typedef enum logic [1:0] {
        BTB_ACT_NONE  = 2'd0,
        BTB_ACT_WRITE = 2'd1,
        BTB_ACT_CLEAR = 2'd2
    } btb_act_e;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 6,
    parameter int ALIGN_BITS = 2,
    localparam int TAG_W     = ADDR_W - IDX_W - ALIGN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Index sits just above the alignment bits; the tag is everything above it.
    assign idx = addr[ALIGN_BITS +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl
    import btb_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             cur_valid,
    input  logic [TAG_W-1:0] cur_tag,
    output btb_act_e         act
);

    logic tag_match;

    assign tag_match = cur_valid && (cur_tag == upd_tag);

    always_comb begin
        act = BTB_ACT_NONE;
        if (upd_valid) begin
            if (upd_taken) begin
                act = BTB_ACT_WRITE;
            end else if (tag_match) begin
                act = BTB_ACT_CLEAR;
            end
        end
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int TGT_W   = 30,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  btb_act_e         act,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_valid,
    output logic [TAG_W-1:0] chk_tag
);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][TGT_W-1:0] tgt;
    } store_t;

    store_t st_d, st_q;

    logic [ENTRIES-1:0] sel;
    logic [ENTRIES-1:0] set_en;
    logic [ENTRIES-1:0] clr_en;

    // One decoder slice per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
        assign sel[g]    = (wr_idx == IDX_W'(g));
        assign set_en[g] = sel[g] && (act == BTB_ACT_WRITE);
        assign clr_en[g] = sel[g] && (act == BTB_ACT_CLEAR);
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.valid = '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (set_en[i]) begin
                    st_d.valid[i] = 1'b1;
                    st_d.tag[i]   = wr_tag;
                    st_d.tgt[i]   = wr_tgt;
                end else if (clr_en[i]) begin
                    st_d.valid[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_valid  = st_q.valid[rd_idx];
    assign rd_tag    = st_q.tag[rd_idx];
    assign rd_tgt    = st_q.tgt[rd_idx];
    assign chk_valid = st_q.valid[chk_idx];
    assign chk_tag   = st_q.tag[chk_idx];

    // An update may change the valid bit of one entry at most.
    AST_ONE_ENTRY_MOVES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(st_q.valid ^ $past(st_q.valid)) <= 1)); // R3

    // A clear leaves its indexed entry empty after the edge.
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (act == BTB_ACT_CLEAR) |=> !st_q.valid[$past(wr_idx)]); // R2

endmodule

// File: rtl/btb_lookup_cmp.sv
module btb_lookup_cmp #(
    parameter int ADDR_W     = 32,
    parameter int TAG_W      = 24,
    parameter int TGT_W      = 30,
    parameter int ALIGN_BITS = 2,
    parameter int STEP_BYTES = 4
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [TAG_W-1:0]  fetch_tag,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [TGT_W-1:0]  ent_tgt,
    output logic              hit,
    output logic [ADDR_W-1:0] next_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] tgt_addr;

    assign hit      = ent_valid && (ent_tag == fetch_tag);
    assign seq_addr = fetch_addr + STEP;
    assign tgt_addr = {ent_tgt, {ALIGN_BITS{1'b0}}};

    always_comb begin
        next_addr = seq_addr;
        if (hit) begin
            next_addr = tgt_addr;
        end
    end

endmodule

// File: rtl/btb_core.sv
module btb_core
    import btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 64,
    parameter int ALIGN_BITS = 2,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] next_fetch,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - ALIGN_BITS;
    localparam int TGT_W = ADDR_W - ALIGN_BITS;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             e_valid, c_valid;
    logic [TAG_W-1:0] e_tag, c_tag;
    logic [TGT_W-1:0] e_tgt;
    btb_act_e         act;

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_fsplit (
        .addr (fetch_addr),
        .idx  (f_idx),
        .tag  (f_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_usplit (
        .addr (upd_addr),
        .idx  (u_idx),
        .tag  (u_tag)
    );

    btb_update_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .upd_valid (upd_valid),
        .upd_taken (upd_taken),
        .upd_tag   (u_tag),
        .cur_valid (c_valid),
        .cur_tag   (c_tag),
        .act       (act)
    );

    btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .wr_idx    (u_idx),
        .wr_tag    (u_tag),
        .wr_tgt    (upd_target[ADDR_W-1:ALIGN_BITS]),
        .rd_idx    (f_idx),
        .rd_valid  (e_valid),
        .rd_tag    (e_tag),
        .rd_tgt    (e_tgt),
        .chk_idx   (u_idx),
        .chk_valid (c_valid),
        .chk_tag   (c_tag)
    );

    btb_lookup_cmp #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TGT_W(TGT_W),
        .ALIGN_BITS(ALIGN_BITS), .STEP_BYTES(STEP_BYTES)
    ) u_cmp (
        .fetch_addr (fetch_addr),
        .fetch_tag  (f_tag),
        .ent_valid  (e_valid),
        .ent_tag    (e_tag),
        .ent_tgt    (e_tgt),
        .hit        (pred_hit),
        .next_addr  (next_fetch)
    );

    AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |=>
            (fetch_addr[ADDR_W-1:ALIGN_BITS] != $past(upd_addr[ADDR_W-1:ALIGN_BITS])) ||
            (pred_hit && next_fetch == {$past(upd_target[ADDR_W-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}})); // R1

    AST_NOT_TAKEN_GONE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |=>
            (fetch_addr[ADDR_W-1:ALIGN_BITS] != $past(upd_addr[ADDR_W-1:ALIGN_BITS])) || !pred_hit); // R2

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_valid) && $stable(fetch_addr)) |->
            ($stable(pred_hit) && $stable(next_fetch))); // R7

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_hit); // R8

endmodule

// File: tb/btb_core_test.sv
`timescale 1ns/1ps
module btb_core_test;

    localparam int AW    = 16;
    localparam int NE    = 8;
    localparam int AL    = 2;
    localparam int STEP  = 4;
    localparam int IW    = 3;
    localparam int TW    = AW - IW - AL;
    localparam int GW    = AW - AL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_addr = '0;
    logic          pred_hit;
    logic [AW-1:0] next_fetch;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic          m_valid [NE];
    logic [TW-1:0] m_tag   [NE];
    logic [GW-1:0] m_tgt   [NE];

    always #2.5 clk = ~clk;

    btb_core #(.ADDR_W(AW), .ENTRIES(NE), .ALIGN_BITS(AL), .STEP_BYTES(STEP)) uut (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .pred_hit(pred_hit),
        .next_fetch(next_fetch), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int low);
        return {TW'(tag), IW'(idx), AL'(low)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
    endtask

    // Presents one resolution for a single cycle and updates the model.
    task automatic do_upd(input logic [AW-1:0] a, input logic t, input logic [AW-1:0] g);
        int ix;
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_taken = t; upd_target = g;
        @(negedge clk);
        upd_valid = 1'b0;
        ix = int'(a[AL +: IW]);
        if (t) begin
            m_valid[ix] = 1'b1; m_tag[ix] = a[AW-1 -: TW]; m_tgt[ix] = g[AW-1:AL];
        end else if (m_valid[ix] && m_tag[ix] == a[AW-1 -: TW]) begin
            m_valid[ix] = 1'b0;
        end
    endtask

    task automatic look(input logic [AW-1:0] a, input string req);
        int ix;
        logic eh;
        logic [AW-1:0] en;
        fetch_addr = a;
        #1;
        ix = int'(a[AL +: IW]);
        eh = m_valid[ix] && (m_tag[ix] == a[AW-1 -: TW]);
        en = eh ? {m_tgt[ix], {AL{1'b0}}} : a + AW'(STEP);
        check(pred_hit == eh, {req, " hit"}, AW'(pred_hit), AW'(eh));
        check(next_fetch == en, {req, " next"}, next_fetch, en);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        int mp;
        logic pr;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 / R5: empty after reset, sequential next address.
        for (int i = 0; i < NE; i++) look(mk(i * 5 + 1, i, i % 4), "R8 R5 reset sweep");

        // R1 / R6: fill every index, look up with all low-bit patterns.
        for (int i = 0; i < NE; i++) do_upd(mk(100 + i, i, 3), 1'b1, AW'(16'h4000 + i * 36 + 3));
        for (int i = 0; i < NE; i++)
            for (int l = 0; l < 4; l++) look(mk(100 + i, i, l), "R1 R6 fill sweep");
        // R6: other tags at the same index miss.
        for (int i = 0; i < NE; i++) look(mk(200 + i, i, 0), "R6 foreign tag");

        // R7: update and lookup of the same address in one cycle, no forwarding.
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = mk(100, 0, 0); upd_taken = 1'b1; upd_target = 16'h7770;
        fetch_addr = mk(100, 0, 0);
        #1;
        check(next_fetch == {m_tgt[0], 2'b00}, "R7 same cycle", next_fetch, {m_tgt[0], 2'b00});
        @(negedge clk);
        upd_valid = 1'b0;
        m_tgt[0] = 14'(16'h7770 >> 2);
        look(mk(100, 0, 0), "R7 after edge");

        // R2: matching not-taken deletes.
        do_upd(mk(103, 3, 1), 1'b0, 16'h0);
        look(mk(103, 3, 0), "R2 deleted");
        // R3: foreign-tag not-taken keeps the entry, and empty index stays empty.
        do_upd(mk(999, 4, 0), 1'b0, 16'h0);
        look(mk(104, 4, 2), "R3 kept");
        do_upd(mk(103, 3, 0), 1'b0, 16'h0);
        for (int i = 0; i < NE; i++) look(mk(100 + i, i, 0), "R3 others intact");

        // R4: taken with a foreign tag replaces.
        do_upd(mk(555, 5, 0), 1'b1, 16'h1238);
        look(mk(105, 5, 0), "R4 old gone");
        look(mk(555, 5, 0), "R4 new present");

        // R9: taken history, then not-taken, then taken: two mispredictions.
        mp = 0;
        do_upd(mk(77, 6, 0), 1'b1, 16'h2000);
        fetch_addr = mk(77, 6, 0); #1; pr = pred_hit;
        if (pr != 1'b0) mp++;
        do_upd(mk(77, 6, 0), 1'b0, 16'h2000);
        fetch_addr = mk(77, 6, 0); #1; pr = pred_hit;
        if (pr != 1'b1) mp++;
        do_upd(mk(77, 6, 0), 1'b1, 16'h2000);
        check(mp == 2, "R9 mispredicts", AW'(mp), AW'(2));

        // R8: reset in the middle of a run empties everything.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        for (int i = 0; i < NE; i++) look(mk(100 + i, i, 0), "R8 mid reset");

        // R1 R2 R3 R4 R5: pseudo-random mix against the model.
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = mk(int'(lf[15:14]), int'(lf[5:3]), int'(lf[1:0]));
            if (lf[8]) do_upd(a, lf[9], {lf[7:0], lf[15:8]});
            look(mk(int'(lf[12:11]), int'(lf[4:2]), int'(lf[7:6])), "R5 random mix");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule